// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors run in parallel on every lookup. One is a table of 2-bit saturating counters indexed by low program-counter bits alone. The other is a table of the same counters indexed by low program-counter bits XORed with a global history of recent branch outcomes. A third table of 2-bit counters, also indexed by the program counter, picks which component supplies the final answer for that branch.

A fetch stage presents a PC on the lookup port. One clock later the block returns the selected direction and the guess of each component. The fetch stage keeps both component guesses with the branch. When the branch resolves, it returns the PC, the real outcome, a flag marking the branch as conditional, and the two guesses it kept. That resolve beat trains both component tables and the selector, and shifts the outcome into the history. The history changes only at resolve time, so it is never speculative and never needs repair.

Top module: `tourney_predictor`

## Requirements
- R1: Every table entry is a 2-bit saturating counter. A taken resolve adds one to it and a not-taken resolve subtracts one. It stays at 2'b11 when incremented and at 2'b00 when decremented.
- R2: A counter's upper bit is its direction: 2'b10 and 2'b11 mean taken, 2'b00 and 2'b01 mean not taken. `pred_bim` and `pred_gsh` report the upper bit of the addressed entry in each component.
- R3: The local component is addressed by `pc[PC_LSB +: BIM_IDX_W]`.
- R4: The global component has 2^G entries, where G = max(BIM_IDX_W, HIST_W). It is addressed by `pc[PC_LSB +: G]` XOR the history zero-extended to G bits.
- R5: A conditional resolve shifts the history left by one and puts the outcome in bit 0 (1 = taken). The resolve indexes the global table with the history as it was before this shift.
- R6: The selector is addressed by `pc[PC_LSB +: CHS_IDX_W]`. Selector values 2'b00 and 2'b01 pass the local guess to `pred_taken`; values 2'b10 and 2'b11 pass the global guess.
- R7: The selector entry moves one step only when `res_bim` and `res_gsh` differ. It moves up when `res_gsh` equals the outcome and down otherwise, and it saturates at both ends. When the two guesses agree, the entry is left unchanged.
- R8: A resolve with `res_cond` low changes no table and does not change the history.
- R9: After reset, every component counter is 2'b01, every selector counter is 2'b01, and the history is all zeros.
- R10: `pred_ok` is high in the cycle after a cycle with `pred_valid` high, and low in every other cycle. The three prediction outputs are valid while `pred_ok` is high.
- R11: When a lookup and a resolve occur in the same cycle, the lookup result is computed from the tables and history as they were before that resolve's update, even when both use the same entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pred_valid | input | 1 | Lookup request |
| pred_pc | input | PC_W | PC of the lookup |
| pred_ok | output | 1 | Lookup result valid (one cycle after request) |
| pred_taken | output | 1 | Selected direction |
| pred_bim | output | 1 | Guess of the PC-indexed component |
| pred_gsh | output | 1 | Guess of the history-hashed component |
| res_valid | input | 1 | Resolve beat |
| res_pc | input | PC_W | PC of the resolved branch |
| res_taken | input | 1 | Actual outcome (1 = taken) |
| res_cond | input | 1 | Branch is conditional; low makes the beat a no-op |
| res_bim | input | 1 | Local guess kept from the lookup |
| res_gsh | input | 1 | Global guess kept from the lookup |

## Verification
A lookup and a resolve can occur in the same cycle, and they can address the same counters and use the same history. The bench draws lookup and resolve PCs from a small pool and asserts both strobes in many cycles, so that same-entry collisions happen often. It also runs a directed case where a lookup and a conditional resolve of one PC share a single edge. The result of each such lookup is judged against a model that computes the prediction from the state before the resolve is applied, and only then trains the model.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;

  // one saturating step toward taken (up=1) or not-taken (up=0)
  function automatic ctr_t sat_step(input ctr_t c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tp_pkg::*;
#(
  parameter int   IDX_W = 6,
  parameter ctr_t INIT  = CTR_WEAK_NT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_q,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];

  // read returns the value held before any write on the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
      rd_q <= INIT;
    end else begin
      rd_q <= mem[rd_idx];
      if (wr_en) mem[wr_idx] <= sat_step(mem[wr_idx], wr_up);
    end
  end
endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] hist_q
);
  generate
    if (W == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= bit_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[W-2:0], bit_in};
      end
    end
  endgenerate
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
  import tp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int BIM_IDX_W = 6,
  parameter int HIST_W    = 8,
  parameter int CHS_IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pred_valid,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_ok,
  output logic            pred_taken,
  output logic            pred_bim,
  output logic            pred_gsh,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic            res_cond,
  input  logic            res_bim,
  input  logic            res_gsh
);
  localparam int GSH_IDX_W = (BIM_IDX_W > HIST_W) ? BIM_IDX_W : HIST_W;

  logic [HIST_W-1:0]    ghist_w;
  logic [GSH_IDX_W-1:0] hist_ext;
  logic                 train;
  logic                 chs_wr;
  ctr_t                 bim_q, gsh_q, chs_q;

  assign hist_ext = GSH_IDX_W'(ghist_w);
  assign train    = res_valid & res_cond;
  assign chs_wr   = train & (res_bim != res_gsh);

  tp_ctr_table #(.IDX_W(BIM_IDX_W), .INIT(CTR_WEAK_NT)) u_bim (
    .clk(clk), .rst(rst),
    .rd_idx(pred_pc[PC_LSB +: BIM_IDX_W]), .rd_q(bim_q),
    .wr_en(train), .wr_idx(res_pc[PC_LSB +: BIM_IDX_W]), .wr_up(res_taken)
  );

  tp_ctr_table #(.IDX_W(GSH_IDX_W), .INIT(CTR_WEAK_NT)) u_gsh (
    .clk(clk), .rst(rst),
    .rd_idx(pred_pc[PC_LSB +: GSH_IDX_W] ^ hist_ext), .rd_q(gsh_q),
    .wr_en(train), .wr_idx(res_pc[PC_LSB +: GSH_IDX_W] ^ hist_ext), .wr_up(res_taken)
  );

  tp_ctr_table #(.IDX_W(CHS_IDX_W), .INIT(CTR_WEAK_NT)) u_chs (
    .clk(clk), .rst(rst),
    .rd_idx(pred_pc[PC_LSB +: CHS_IDX_W]), .rd_q(chs_q),
    .wr_en(chs_wr), .wr_idx(res_pc[PC_LSB +: CHS_IDX_W]), .wr_up(res_gsh == res_taken)
  );

  tp_ghist #(.W(HIST_W)) u_hist (
    .clk(clk), .rst(rst), .shift_en(train), .bit_in(res_taken), .hist_q(ghist_w)
  );

  always_ff @(posedge clk) begin
    if (rst) pred_ok <= 1'b0;
    else     pred_ok <= pred_valid;
  end

  assign pred_bim   = bim_q[1];
  assign pred_gsh   = gsh_q[1];
  assign pred_taken = chs_q[1] ? gsh_q[1] : bim_q[1];
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int HIST_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pred_valid,
  input logic              pred_ok,
  input logic              pred_taken,
  input logic              pred_bim,
  input logic              pred_gsh,
  input logic              res_valid,
  input logic              res_cond,
  input logic              res_taken,
  input logic [HIST_W-1:0] ghist_w
);
  assert_hist_shift_R5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_cond) |=> ghist_w == HIST_W'({$past(ghist_w), $past(res_taken)}));

  assert_hist_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && res_cond) |=> $stable(ghist_w));

  assert_hist_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ghist_w == '0);

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    pred_valid |=> pred_ok);

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (rst)
    !pred_valid |=> !pred_ok);

  assert_select_source_R6: assert property (@(posedge clk) disable iff (rst)
    pred_ok |-> (pred_taken == pred_bim || pred_taken == pred_gsh));

  assert_agree_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (pred_ok && pred_bim == pred_gsh) |-> pred_taken == pred_bim);
endmodule

bind tourney_predictor tp_checker #(.HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst(rst), .pred_valid(pred_valid), .pred_ok(pred_ok),
  .pred_taken(pred_taken), .pred_bim(pred_bim), .pred_gsh(pred_gsh),
  .res_valid(res_valid), .res_cond(res_cond), .res_taken(res_taken),
  .ghist_w(ghist_w)
);

// File: tb/tourney_predictor_test.sv
module tourney_predictor_test;
  localparam int PC_W = 32, PC_LSB = 2, BW = 6, HW = 8, CW = 6;
  localparam int GW = (BW > HW) ? BW : HW;

  logic clk = 1'b0, rst = 1'b1;
  logic pred_valid = 0, res_valid = 0, res_taken = 0, res_cond = 0, res_bim = 0, res_gsh = 0;
  logic [PC_W-1:0] pred_pc = '0, res_pc = '0;
  logic pred_ok, pred_taken, pred_bim, pred_gsh;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [1:0] m_bim [1<<BW];
  logic [1:0] m_gsh [1<<GW];
  logic [1:0] m_chs [1<<CW];
  logic [HW-1:0] m_hist;

  always #5 clk = ~clk;

  tourney_predictor #(.PC_W(PC_W), .PC_LSB(PC_LSB), .BIM_IDX_W(BW), .HIST_W(HW), .CHS_IDX_W(CW)) uut (
    .clk(clk), .rst(rst), .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_ok(pred_ok), .pred_taken(pred_taken), .pred_bim(pred_bim), .pred_gsh(pred_gsh),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken), .res_cond(res_cond),
    .res_bim(res_bim), .res_gsh(res_gsh)
  );

  function automatic logic [1:0] f_step(input logic [1:0] c, input logic up);  // R1
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction
  function automatic int f_bidx(input logic [PC_W-1:0] pc);  // R3
    return int'(pc[PC_LSB +: BW]);
  endfunction
  function automatic int f_gidx(input logic [PC_W-1:0] pc, input logic [HW-1:0] h);  // R4
    return int'(pc[PC_LSB +: GW] ^ GW'(h));
  endfunction
  function automatic int f_cidx(input logic [PC_W-1:0] pc);  // R6
    return int'(pc[PC_LSB +: CW]);
  endfunction

  task automatic model_reset();  // R9
    for (int i = 0; i < (1<<BW); i++) m_bim[i] = 2'b01;
    for (int i = 0; i < (1<<GW); i++) m_gsh[i] = 2'b01;
    for (int i = 0; i < (1<<CW); i++) m_chs[i] = 2'b01;
    m_hist = '0;
  endtask

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {ok/taken,bim,gsh} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, clock, check at next negedge. Model uses pre-update state (R11).
  task automatic cycle(input string req, input logic pv, input logic [PC_W-1:0] ppc,
                       input logic rv, input logic [PC_W-1:0] rpc, input logic rt,
                       input logic rc, input logic rb, input logic rg);
    logic eb, eg, et;
    pred_valid = pv; pred_pc = ppc; res_valid = rv; res_pc = rpc;
    res_taken = rt; res_cond = rc; res_bim = rb; res_gsh = rg;
    eb = m_bim[f_bidx(ppc)][1];
    eg = m_gsh[f_gidx(ppc, m_hist)][1];
    et = m_chs[f_cidx(ppc)][1] ? eg : eb;
    if (rv && rc) begin  // R8: nothing happens otherwise
      m_bim[f_bidx(rpc)] = f_step(m_bim[f_bidx(rpc)], rt);
      m_gsh[f_gidx(rpc, m_hist)] = f_step(m_gsh[f_gidx(rpc, m_hist)], rt);
      if (rb != rg) m_chs[f_cidx(rpc)] = f_step(m_chs[f_cidx(rpc)], rg == rt);  // R7
      m_hist = {m_hist[HW-2:0], rt};  // R5
    end
    @(negedge clk);
    if (pv) check(req, {pred_taken, pred_bim, pred_gsh}, {et, eb, eg});
    check({req, " R10 valid"}, {2'b00, pred_ok}, {2'b00, pv});
  endtask

  function automatic logic [PC_W-1:0] mkpc(input int k);
    return PC_W'(k) << PC_LSB;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state: all weakly not-taken, selector on local
    cycle("R9 reset", 1, mkpc(5), 0, '0, 0, 0, 0, 0);
    // R1 saturation up: five taken resolves on one PC
    for (int i = 0; i < 5; i++) cycle("R1 sat up", 1, mkpc(9), 1, mkpc(9), 1, 1, 0, 0);
    cycle("R1 R2 after up", 1, mkpc(9), 0, '0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cycle("R1 sat down", 1, mkpc(9), 1, mkpc(9), 0, 1, 1, 1);
    cycle("R1 R2 after down", 1, mkpc(9), 0, '0, 0, 0, 0, 0);
    // R8: unconditional resolves must change nothing
    for (int i = 0; i < 4; i++) cycle("R8 ignore", 0, '0, 1, mkpc(3), 1, 0, 0, 1);
    cycle("R8 probe", 1, mkpc(3), 0, '0, 0, 0, 0, 0);
    // R7: selector pushed toward global, then agreeing beats leave it
    for (int i = 0; i < 3; i++) cycle("R7 toward global", 1, mkpc(12), 1, mkpc(12), 1, 1, 0, 1);
    for (int i = 0; i < 3; i++) cycle("R7 agree hold", 1, mkpc(12), 1, mkpc(12), 0, 1, 1, 1);
    // R11: lookup and resolve of the same PC on one edge
    for (int i = 0; i < 6; i++) cycle("R11 collide", 1, mkpc(7), 1, mkpc(7), 1, 1, i[0], ~i[0]);
    // R4 R5 R6 random mix from a small PC pool
    for (int i = 0; i < 3000; i++) begin
      logic pv, rv, rt, rc, rb, rg;
      logic [PC_W-1:0] ppc, rpc;
      pv = ($urandom % 4) != 0; rv = ($urandom % 3) != 0;
      ppc = mkpc(int'($urandom % 24)); rpc = ($urandom % 3 == 0) ? ppc : mkpc(int'($urandom % 24));
      rt = ($urandom % 4) != 0; rc = ($urandom % 8) != 0;
      rb = $urandom % 2; rg = $urandom % 2;
      cycle("R4 R5 R6 random", pv, ppc, rv, rpc, rt, rc, rb, rg);
    end
    // R9: reset mid-run restores initial state
    rst = 1; pred_valid = 0; res_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0; model_reset();
    cycle("R9 re-reset", 1, mkpc(9), 0, '0, 0, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule